// File: doc/BRIEF.md
# Serial Sampling Converter Front End with Power Modes

This block is the digital half of a four-channel, 12-bit serial sampling converter, written to be synthesizable so that it can stand in for the converter in a chip-level simulation. A host frames each transfer with an active-low chip select and a serial clock. In every frame the block shifts out a 16-bit result word and shifts in a 12-bit control word. The control word picks the channel that the next conversion reports and sets one of three power behaviours. A parallel sample input takes the place of the analog core. Two status outputs show whether the track/hold is holding and whether the core is fully powered.

The chip select, serial clock and data input are sampled on the system clock, and their edges are found from those samples. A control word takes effect only at the sixteenth serial clock falling edge of a frame, and only when its write bit is set. The power-mode changes that follow a frame happen when chip select rises. Waking up takes a number of system clocks set by the `wakeLimit` input. A frame that starts before the core is fully powered still runs, but `frameBad` marks its result as invalid.

Top module: `serial_adc_port`

## Requirements
- R1: When `csN` falls while `powered` is 1, `holdActive` goes to 1, `doutEn` goes to 1, and `dout` presents the first bit of the result word.
- R2: The result word is sent MSB first: bits 15:14 are zero, bits 13:12 are the channel held in the control register when the frame started, and bits 11:0 are `sampleIn` captured at the `csN` falling edge. Bit 15-k is presented after the k-th `sclk` falling edge.
- R3: `din` is sampled on `sclk` falling edges, MSB first. The first 12 bits form the control word: bit 11 is write, bits 9:8 are the power mode, bits 7:6 are the channel, and the other bits are ignored. The word is loaded at the 16th falling edge only when bit 11 is 1. When bit 11 is 0, channel and power mode stay as they were.
- R4: If `csN` rises before the 16th `sclk` falling edge, the frame is aborted and the control register keeps its previous value.
- R5: `holdActive` stays 1 through the 13th `sclk` falling edge of a frame and drops to 0 at the 14th.
- R6: Power mode 11 (and the unused code 00) keeps the core powered across frames.
- R7: After a completed frame with power mode 10, `powered` drops to 0 and `holdActive` goes to 1 at the `csN` rising edge. Later frames leave `doutEn` at 0, and the control register is kept.
- R8: When a frame that started in full shutdown loads power mode 11, `doutEn` stays 0 for that frame. The wake counter starts at the `csN` rising edge, and `powered` returns to 1 `wakeLimit`+1 system clocks later.
- R9: In power mode 01 the core powers down (`powered` 0, `holdActive` 1) at the `csN` rising edge of every frame that loaded the register. The next `csN` falling edge puts the track/hold in track and starts the wake counter. A frame with write bit 0 does not power the core down.
- R10: `frameBad` is set for the whole of a frame that starts while `powered` is 0, and cleared for a frame that starts while `powered` is 1.
- R11: After reset the power mode is 11 and the channel is 0, `powered` is 1, and `holdActive`, `doutEn` and `dout` are 0.
- R12: `doutEn` is 0 whenever no frame is open (`csN` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial control data in |
| sampleIn | input | 12 | Parallel conversion value from the analog model |
| wakeLimit | input | WAKE_W | System clocks needed to finish waking |
| dout | output | 1 | Serial result data, 0 when not driven |
| doutEn | output | 1 | Output enable for the `dout` tri-state buffer |
| holdActive | output | 1 | Track/hold is in hold |
| powered | output | 1 | Core fully powered |
| frameBad | output | 1 | Result of the current or last frame is invalid |

## Verification
The bench sweeps every channel with several sample patterns. A design that latched the channel at the wrong time, or shifted one edge early, would report the wrong identifier or a rotated sample. Aborted frames and frames with the write bit clear are followed by a read-back of the channel identifier, so a design that committed a partial or unwritten word would show up there. The power sequences cover three cases: full shutdown with an undriven wake frame, auto shutdown with a dummy frame that must not shut the core down again, and invalid-result flagging. A design that powered down on the wrong edge, drove `dout` while quiet, or flagged results off by one frame would fail those checks.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int SAMPLE_W   = 12;
  localparam int CHAN_W     = 2;
  localparam int LEAD_W     = 2;
  localparam int WORD_W     = LEAD_W + CHAN_W + SAMPLE_W;
  localparam int CTRL_W     = 12;
  localparam int WR_POS     = 11;
  localparam int PM_LO      = 8;
  localparam int CH_LO      = 6;
  localparam int TRACK_EDGE = 14;
  localparam int EDGE_W     = $clog2(WORD_W + 1);

  localparam logic [1:0] PM_NORMAL = 2'b11;
  localparam logic [1:0] PM_FULL   = 2'b10;
  localparam logic [1:0] PM_AUTO   = 2'b01;

  typedef enum logic [1:0] {
    PWR_ON, PWR_WAKE, PWR_AUTO_OFF, PWR_FULL_OFF
  } pwr_e;

  typedef struct packed {
    logic loadWord;
    logic shiftOut;
    logic shiftIn;
    logic commit;
    logic bitIn;
  } strobe_t;

  typedef struct packed {
    logic [1:0]        pm;
    logic [CHAN_W-1:0] chan;
  } cfg_t;
endpackage

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import sadc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output cfg_t                cfg,
  output logic                wrReq,
  output logic                txBit
);
  logic [WORD_W-1:0] txShift;
  logic [CTRL_W-1:0] rxShift;
  cfg_t              cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      cfgQ.pm   <= PM_NORMAL;
      cfgQ.chan <= '0;
    end else begin
      if (stb.loadWord)
        txShift <= {{LEAD_W{1'b0}}, cfgQ.chan, sampleIn};
      else if (stb.shiftOut)
        txShift <= {txShift[WORD_W-2:0], 1'b0};
      if (stb.shiftIn)
        rxShift <= {rxShift[CTRL_W-2:0], stb.bitIn};
      if (stb.commit && rxShift[WR_POS]) begin
        cfgQ.pm   <= rxShift[PM_LO +: 2];
        cfgQ.chan <= rxShift[CH_LO +: CHAN_W];
      end
    end
  end

  assign cfg   = cfgQ;
  assign wrReq = rxShift[WR_POS];
  assign txBit = txShift[WORD_W-1];
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int WAKE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic [WAKE_W-1:0] wakeLimit,
  input  logic [1:0]        pm,
  input  logic              wrReq,
  output strobe_t           stb,
  output logic              frameOn,
  output logic              quietFrame,
  output logic              holdActive,
  output logic              powered,
  output logic              frameBad
);
  logic              csS, csD, sclkS, sclkD, dinS;
  logic              active, complete, updated, hold, bad, quiet;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] nextCnt;
  logic [WAKE_W-1:0] wakeCnt;
  pwr_e              state, tickState, riseState;
  logic              csFall, csRise, sclkFall;

  assign csFall   = csD & ~csS;
  assign csRise   = ~csD & csS & active;
  assign sclkFall = sclkD & ~sclkS & active & ~csS
                  & (edgeCnt < EDGE_W'(WORD_W));
  assign nextCnt  = edgeCnt + 1'b1;

  assign stb.loadWord = csFall;
  assign stb.shiftOut = sclkFall && (nextCnt < EDGE_W'(WORD_W));
  assign stb.shiftIn  = sclkFall && (nextCnt <= EDGE_W'(CTRL_W));
  assign stb.commit   = sclkFall && (nextCnt == EDGE_W'(WORD_W));
  assign stb.bitIn    = dinS;

  always_comb begin
    tickState = state;
    if (state == PWR_WAKE && wakeCnt >= wakeLimit) tickState = PWR_ON;
    riseState = tickState;
    if (complete) begin
      if (pm == PM_FULL)                 riseState = PWR_FULL_OFF;
      else if (pm == PM_AUTO && updated) riseState = PWR_AUTO_OFF;
      else if (tickState == PWR_FULL_OFF) riseState = PWR_WAKE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csS      <= 1'b1;
      csD      <= 1'b1;
      sclkS    <= 1'b1;
      sclkD    <= 1'b1;
      dinS     <= 1'b0;
      active   <= 1'b0;
      complete <= 1'b0;
      updated  <= 1'b0;
      hold     <= 1'b0;
      bad      <= 1'b0;
      quiet    <= 1'b0;
      edgeCnt  <= '0;
      wakeCnt  <= '0;
      state    <= PWR_ON;
    end else begin
      csS   <= csN;
      csD   <= csS;
      sclkS <= sclk;
      sclkD <= sclkS;
      dinS  <= din;

      state <= tickState;
      if (state == PWR_WAKE && wakeCnt < wakeLimit) wakeCnt <= wakeCnt + 1'b1;

      if (csFall) begin
        active   <= 1'b1;
        edgeCnt  <= '0;
        complete <= 1'b0;
        updated  <= 1'b0;
        bad      <= (state != PWR_ON);
        quiet    <= (state == PWR_FULL_OFF);
        if (state == PWR_AUTO_OFF) begin
          state   <= PWR_WAKE;
          wakeCnt <= '0;
          hold    <= 1'b0;
        end else begin
          hold <= 1'b1;
        end
      end

      if (csRise) begin
        active <= 1'b0;
        state  <= riseState;
        hold   <= (riseState == PWR_FULL_OFF) || (riseState == PWR_AUTO_OFF);
        if (riseState == PWR_WAKE && tickState != PWR_WAKE) wakeCnt <= '0;
      end

      if (sclkFall) begin
        edgeCnt <= nextCnt;
        if (nextCnt == EDGE_W'(TRACK_EDGE)) hold <= 1'b0;
        if (nextCnt == EDGE_W'(WORD_W)) begin
          complete <= 1'b1;
          updated  <= wrReq;
        end
      end
    end
  end

  assign frameOn    = active;
  assign quietFrame = quiet;
  assign holdActive = hold;
  assign powered    = (state == PWR_ON);
  assign frameBad   = bad;
endmodule

// File: rtl/serial_adc_port.sv
module serial_adc_port
  import sadc_pkg::*;
#(
  parameter int WAKE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                din,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [WAKE_W-1:0]   wakeLimit,
  output logic                dout,
  output logic                doutEn,
  output logic                holdActive,
  output logic                powered,
  output logic                frameBad
);
  strobe_t stb;
  cfg_t    cfg;
  logic    wrReq, txBit, frameOn, quietFrame;

  sadc_ctrl #(.WAKE_W(WAKE_W)) ctrlU (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .wakeLimit(wakeLimit), .pm(cfg.pm), .wrReq(wrReq), .stb(stb),
    .frameOn(frameOn), .quietFrame(quietFrame), .holdActive(holdActive),
    .powered(powered), .frameBad(frameBad)
  );

  sadc_datapath dpU (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleIn(sampleIn),
    .cfg(cfg), .wrReq(wrReq), .txBit(txBit)
  );

  assign doutEn = frameOn & ~quietFrame;
  assign dout   = doutEn ? txBit : 1'b0;
endmodule

// File: rtl/sadc_checker.sv
module sadc_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic doutEn,
  input logic holdActive,
  input logic powered,
  input logic frameBad
);
  logic [1:0] sinceRst;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end
  assign warm = (sinceRst == 2'd3);

  AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(csN) && $past(csN, 2)) |-> !doutEn); // R12

  AST_BAD_FOLLOWS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $rose(doutEn)) |-> (frameBad == !$past(powered))); // R10

  AST_HOLD_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $rose(doutEn) && $past(powered)) |-> holdActive); // R1

  AST_DOWN_ON_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $fell(powered)) |-> ($past(csN) && holdActive)); // R7

  AST_BAD_STABLE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (warm && doutEn && $past(doutEn)) |-> $stable(frameBad)); // R10
endmodule

bind serial_adc_port sadc_checker chkU (
  .clk(clk), .rstN(rstN), .csN(csN), .doutEn(doutEn),
  .holdActive(holdActive), .powered(powered), .frameBad(frameBad)
);

// File: tb/serial_adc_port_test.sv
module serial_adc_port_test;
  localparam int WAKE_W = 16;
  localparam int WAKE_N = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [11:0] sampleIn = '0;
  logic [WAKE_W-1:0] wakeLimit = WAKE_W'(WAKE_N);
  logic dout, doutEn, holdActive, powered, frameBad;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [1:0] expCh;

  logic [15:0] word;
  logic sawEn, holdStart, hold13, hold14, badSeen;

  serial_adc_port #(.WAKE_W(WAKE_W)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .sampleIn(sampleIn), .wakeLimit(wakeLimit), .dout(dout), .doutEn(doutEn),
    .holdActive(holdActive), .powered(powered), .frameBad(frameBad)
  );

  always #10 clk = ~clk;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] mkCtrl(input logic wr, input logic [1:0] pm,
                                         input logic [1:0] ch);
    return {wr, 1'b0, pm, ch, 6'b000000};
  endfunction

  task automatic runFrame(input logic [11:0] ctrlWord, input logic [11:0] smp,
                          input int edges);
    sampleIn = smp;
    din = ctrlWord[11];
    hold13 = 1'bx;
    hold14 = 1'bx;
    csN = 1'b0;
    waitClk(4);
    word = '0;
    word[15] = dout;
    sawEn = doutEn;
    holdStart = holdActive;
    badSeen = frameBad;
    for (int k = 1; k <= edges; k++) begin
      din = (k <= 12) ? ctrlWord[12-k] : 1'b0;
      waitClk(4);
      sclk = 1'b0;
      waitClk(4);
      if (k < 16) word[15-k] = dout;
      sawEn = sawEn | doutEn;
      if (k == 13) hold13 = holdActive;
      if (k == 14) hold14 = holdActive;
      sclk = 1'b1;
      waitClk(4);
    end
    csN = 1'b1;
    waitClk(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog all-reqs actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    // R11 reset state
    check(powered == 1'b1, "R11 powered", powered, 1);
    check(holdActive == 1'b0, "R11 hold", holdActive, 0);
    check(doutEn == 1'b0 && dout == 1'b0, "R11 dout", {doutEn, dout}, 0);
    expCh = 2'd0;

    // Sweep over all channels and sample patterns (R1 R2 R3 R5 R6 R10)
    for (int ch = 0; ch < 4; ch++) begin
      for (int i = 0; i < 4; i++) begin
        logic [11:0] smp;
        logic [1:0]  w;
        smp = (i == 0) ? 12'h000 : (i == 1) ? 12'hFFF :
              12'((ch + 1) * 711) ^ 12'(i * 2323);
        w = 2'((ch + i) & 3);
        runFrame(mkCtrl(1'b1, 2'b11, w), smp, 16);
        check(word == {2'b00, expCh, smp}, "R2 result word", word, {2'b00, expCh, smp});
        check(holdStart == 1'b1 && sawEn == 1'b1, "R1 start", {holdStart, sawEn}, 2'b11);
        check(hold13 == 1'b1 && hold14 == 1'b0, "R5 track edge", {hold13, hold14}, 2'b10);
        check(badSeen == 1'b0, "R10 valid frame", badSeen, 0);
        check(powered == 1'b1, "R6 stays up", powered, 1);
        check(doutEn == 1'b0, "R12 idle quiet", doutEn, 0);
        expCh = w;
      end
    end

    // R3: write bit clear leaves register
    runFrame(mkCtrl(1'b0, 2'b10, 2'd1), 12'h123, 16);
    runFrame(mkCtrl(1'b1, 2'b11, 2'd2), 12'h456, 16);
    check(word == {2'b00, expCh, 12'h456}, "R3 write bit clear", word, {2'b00, expCh, 12'h456});
    check(powered == 1'b1, "R3 power bits kept", powered, 1);
    expCh = 2'd2;

    // R4: aborted frame does not commit
    runFrame(mkCtrl(1'b1, 2'b11, 2'd1), 12'h777, 10);
    check(doutEn == 1'b0, "R12 after abort", doutEn, 0);
    runFrame(mkCtrl(1'b1, 2'b11, 2'd2), 12'h0F0, 16);
    check(word[13:12] == 2'd2, "R4 abort ignored", word[13:12], 2);

    // R7 full shutdown
    runFrame(mkCtrl(1'b1, 2'b10, 2'd2), 12'h321, 16);
    check(powered == 1'b0 && holdActive == 1'b1, "R7 enter full off", {powered, holdActive}, 2'b01);
    runFrame(mkCtrl(1'b0, 2'b11, 2'd1), 12'h111, 16);
    check(sawEn == 1'b0, "R7 dout undriven", sawEn, 0);
    check(badSeen == 1'b1, "R10 bad while off", badSeen, 1);
    check(powered == 1'b0, "R7 still off", powered, 0);
    // R8 wake frame
    runFrame(mkCtrl(1'b1, 2'b11, 2'd2), 12'h222, 16);
    check(sawEn == 1'b0, "R8 wake frame undriven", sawEn, 0);
    check(powered == 1'b0, "R8 not yet up", powered, 0);
    waitClk(WAKE_N + 4);
    check(powered == 1'b1, "R8 up after wake", powered, 1);
    runFrame(mkCtrl(1'b1, 2'b11, 2'd2), 12'hABC, 16);
    check(word == {2'b00, 2'd2, 12'hABC}, "R7 register retained", word, {2'b00, 2'd2, 12'hABC});
    check(badSeen == 1'b0, "R10 valid after wake", badSeen, 0);

    // R9 auto shutdown
    runFrame(mkCtrl(1'b1, 2'b01, 2'd3), 12'h5A5, 16);
    check(powered == 1'b0 && holdActive == 1'b1, "R9 auto down", {powered, holdActive}, 2'b01);
    runFrame(mkCtrl(1'b0, 2'b00, 2'd0), 12'h9C3, 16);
    check(holdStart == 1'b0, "R9 track on select", holdStart, 0);
    check(badSeen == 1'b1 && sawEn == 1'b1, "R10 dummy flagged", {badSeen, sawEn}, 2'b11);
    check(word == {2'b00, 2'd3, 12'h9C3}, "R9 dummy word", word, {2'b00, 2'd3, 12'h9C3});
    check(powered == 1'b1, "R9 dummy keeps up", powered, 1);
    runFrame(mkCtrl(1'b1, 2'b01, 2'd0), 12'h3C3, 16);
    check(badSeen == 1'b0 && holdStart == 1'b1, "R10 auto valid", {badSeen, holdStart}, 2'b01);
    check(word == {2'b00, 2'd3, 12'h3C3}, "R2 auto word", word, {2'b00, 2'd3, 12'h3C3});
    check(powered == 1'b0, "R9 down again", powered, 0);
    runFrame(mkCtrl(1'b1, 2'b11, 2'd0), 12'h000, 16);
    check(badSeen == 1'b1, "R10 wake frame bad", badSeen, 1);
    check(powered == 1'b1, "R6 back to normal", powered, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule